// File: doc/BRIEF.md
# Video Timing Register File

This block is the software-visible parameter store of a raster display controller. A host writes horizontal and vertical timing values, a framebuffer start address, a line stride, a pixel-clock divide setting and interrupt enables over a simple 32-bit little-endian register bus. The block trims every write to the bits that register implements and presents the stored values to the timing generator and pixel fetch logic. Registers sit on a 16-byte stride, so the register number is the byte offset shifted right by four.

A control register gates the display on and off. A new on/off setting takes effect only after the host has confirmed it with a series of strobe toggles. A vertical-blank input sets two interrupt status bits. The same input drives an interrupt request, but only when the display is running and the interrupt enable allows it. Whenever a parameter that shapes the raster changes while the display runs, the block raises a one-cycle reload pulse so downstream timing can pick up the new values.

Top module: `vtr_regfile`

## Requirements
- R1: The register number is byte offset bits [8:4]. Offset bits [3:0] are ignored. A read issued in one cycle returns its data on `bus_rdata` after the next rising edge, and that data holds until the next read.
- R2: Registers 1 to 16 are timing parameters that keep the low 12 bits of a write. Register 8 keeps 10 bits and register 14 keeps 8 bits. Register n reads back its stored value and drives `timing_o[(n-1)*12 +: 12]`.
- R3: Register 19 (frame base) keeps `wdata & 0x3FFFE0`. Register 20 (stride) keeps `wdata & 0x7FE0`. Both read back what they keep and drive `fb_base_o` and `row_stride_o`. They hold their value when no write is made.
- R4: Register 23 (divide) keeps 2 bits, register 25 (interrupt enable) keeps 4 bits and register 18 (control) keeps 11 bits. Each reads back the kept value.
- R5: Registers 0, 17 and 24 read as zero, and writes to them change nothing that can be read. Register 21 reads `mon_id << 6`.
- R6: Register numbers 22 and 27 to 31 read as zero, and writes to them change no stored value.
- R7: In the control register, bit 10 is display-off. A write that changes bit 10 stores the value and clears a toggle count. Any other changing write stores the value and counts up, saturating at 3. When the count is 3 and bit 10 differs from the last committed control value, that value is committed and `display_on_o` becomes the inverse of bit 10. The committed value starts at 0x433, so the display is off after reset.
- R8: Register 26 (status) reads 0xC one cycle after `vblank` is high and 0x0 one cycle after it is low.
- R9: `irq_o` equals, one cycle later, `vblank` AND `display_on_o` AND interrupt-enable bit 2.
- R10: `commit_o` pulses for one cycle after a write to register 1 to 16, 19, 20 or 23 made while `display_on_o` is high. It stays low for such writes made while the display is off.
- R11: After reset all stored registers, `bus_rdata`, `display_on_o`, `irq_o` and `commit_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| vblank | input | 1 | Vertical-blank level from the timing generator |
| mon_id | input | 3 | Attached monitor code |
| timing_o | output | 192 | Timing parameters 1..16, 12 bits each |
| fb_base_o | output | 22 | Framebuffer base, 32-byte aligned |
| row_stride_o | output | 15 | Line stride, 32-byte aligned |
| clk_div_o | output | 2 | Pixel clock divide setting |
| display_on_o | output | 1 | Display enabled |
| irq_o | output | 1 | Vertical-blank interrupt request |
| commit_o | output | 1 | One-cycle reload pulse |

## Verification
A wrong toggle count or a wrong committed control value shows up at `display_on_o`. The display then switches on one write too early or too late, or it never switches. A strobe sequence therefore exposes the fault within three control writes. A bad mask or a bad decode of a register number appears at the next readback of that register, and on its parameter output one cycle after the write. Faults in the status or interrupt gating appear on `irq_o` or on a status read within one cycle of a change on `vblank`. The reload pulse is checked in the cycle right after each write, both with the display on and with it off.

// File: rtl/vtr_pkg.sv
package vtr_pkg;
    localparam int IDX_W    = 5;
    localparam int N_TIMING = 16;

    // register numbers whose position other logic depends on
    localparam logic [IDX_W-1:0] IX_T_FIRST  = 5'd1;
    localparam logic [IDX_W-1:0] IX_T_LAST   = 5'd16;
    localparam logic [IDX_W-1:0] IX_CTRL     = 5'd18;
    localparam logic [IDX_W-1:0] IX_BASE     = 5'd19;
    localparam logic [IDX_W-1:0] IX_STRIDE   = 5'd20;
    localparam logic [IDX_W-1:0] IX_MON      = 5'd21;
    localparam logic [IDX_W-1:0] IX_DIV      = 5'd23;
    localparam logic [IDX_W-1:0] IX_INTEN    = 5'd25;
    localparam logic [IDX_W-1:0] IX_STATUS   = 5'd26;

    typedef struct packed {
        logic timing;
        logic ctrl;
        logic base;
        logic stride;
        logic mon;
        logic div;
        logic inten;
        logic status;
    } sel_t;

    // number of implemented bits of timing register idx
    function automatic int timing_bits(input int idx, input int tw);
        if (idx == 8)  return 10;
        if (idx == 14) return 8;
        return tw;
    endfunction
endpackage

// File: rtl/vtr_decode.sv
module vtr_decode
    import vtr_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int SLOT_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output sel_t              sel
);
    logic [IDX_W-1:0] idx;
    logic [3:0]       unused_low;

    assign idx        = addr[ADDR_W-1:4];
    assign unused_low = addr[3:0];
    assign slot       = SLOT_W'(idx - IX_T_FIRST);

    always_comb begin
        sel = '0;
        if (idx >= IX_T_FIRST && idx <= IX_T_LAST) sel.timing = 1'b1;
        if (idx == IX_CTRL)   sel.ctrl   = 1'b1;
        if (idx == IX_BASE)   sel.base   = 1'b1;
        if (idx == IX_STRIDE) sel.stride = 1'b1;
        if (idx == IX_MON)    sel.mon    = 1'b1;
        if (idx == IX_DIV)    sel.div    = 1'b1;
        if (idx == IX_INTEN)  sel.inten  = 1'b1;
        if (idx == IX_STATUS) sel.status = 1'b1;
    end
endmodule

// File: rtl/vtr_ctrl_latch.sv
module vtr_ctrl_latch #(
    parameter int              CTRL_W      = 11,
    parameter int              OFF_BIT     = 10,
    parameter int              TOGGLES     = 3,
    parameter logic [CTRL_W-1:0] COMMIT_INIT = 'h433
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              on_o
);
    localparam int CNT_W = $clog2(TOGGLES + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CTRL_W-1:0] committed;
        logic [CNT_W-1:0]  cnt;
        logic              on;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && wdata != st_q.ctrl) begin
            st_d.ctrl = wdata;
            if (wdata[OFF_BIT] != st_q.ctrl[OFF_BIT]) begin
                st_d.cnt = '0;
            end else begin
                if (st_q.cnt != CNT_W'(TOGGLES)) st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_d.cnt == CNT_W'(TOGGLES) &&
                    wdata[OFF_BIT] != st_q.committed[OFF_BIT]) begin
                    st_d.on        = ~wdata[OFF_BIT];
                    st_d.committed = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.committed <= COMMIT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign on_o   = st_q.on;
endmodule

// File: rtl/vtr_irq.sv
module vtr_irq #(
    parameter int            ST_W     = 4,
    parameter logic [ST_W-1:0] VBL_BITS = 'hC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vblank,
    input  logic            display_on,
    input  logic            enable,
    output logic [ST_W-1:0] status_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [ST_W-1:0] status;
        logic            irq;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d.status = vblank ? VBL_BITS : '0;
        st_d.irq    = vblank & display_on & enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/vtr_regfile.sv
module vtr_regfile
    import vtr_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 32,
    parameter int TW         = 12,
    parameter int BASE_W     = 22,
    parameter int STRIDE_W   = 15,
    parameter int ALIGN_W    = 5,
    parameter int DIV_W      = 2,
    parameter int INTEN_W    = 4,
    parameter int IRQ_EN_BIT = 2,
    parameter int CTRL_W     = 11,
    parameter int ST_W       = 4,
    parameter int MON_W      = 3,
    parameter int MON_SHIFT  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   vblank,
    input  logic [MON_W-1:0]       mon_id,
    output logic [N_TIMING*TW-1:0] timing_o,
    output logic [BASE_W-1:0]      fb_base_o,
    output logic [STRIDE_W-1:0]    row_stride_o,
    output logic [DIV_W-1:0]       clk_div_o,
    output logic                   display_on_o,
    output logic                   irq_o,
    output logic                   commit_o
);
    localparam int SLOT_W = $clog2(N_TIMING);
    localparam logic [BASE_W-1:0]   BASE_KEEP   = {{(BASE_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};
    localparam logic [STRIDE_W-1:0] STRIDE_KEEP = {{(STRIDE_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

    typedef struct packed {
        logic [N_TIMING-1:0][TW-1:0] timing;
        logic [BASE_W-1:0]           base;
        logic [STRIDE_W-1:0]         stride;
        logic [DIV_W-1:0]            div;
        logic [INTEN_W-1:0]          inten;
        logic [DATA_W-1:0]           rdata;
        logic                        commit;
    } regs_t;

    regs_t st_d, st_q;

    sel_t                 sel;
    logic [SLOT_W-1:0]    slot;
    logic [CTRL_W-1:0]    ctrl_w;
    logic                 display_on_w;
    logic [ST_W-1:0]      status_w;
    logic                 inten_irq_w;
    logic [DATA_W-1:0]    rd_val;
    logic [DATA_W-1:0]    unused_wdata;
    logic [N_TIMING-1:0][TW-1:0] tmask;

    assign unused_wdata = bus_wdata;
    assign inten_irq_w  = st_q.inten[IRQ_EN_BIT];

    vtr_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
        .addr (bus_addr),
        .slot (slot),
        .sel  (sel)
    );

    vtr_ctrl_latch #(.CTRL_W(CTRL_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr & sel.ctrl),
        .wdata  (bus_wdata[CTRL_W-1:0]),
        .ctrl_o (ctrl_w),
        .on_o   (display_on_w)
    );

    vtr_irq #(.ST_W(ST_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .vblank     (vblank),
        .display_on (display_on_w),
        .enable     (inten_irq_w),
        .status_o   (status_w),
        .irq_o      (irq_o)
    );

    // per-register keep masks and parameter outputs
    for (genvar k = 0; k < N_TIMING; k++) begin : g_timing
        assign tmask[k] = TW'((1 << timing_bits(k + 1, TW)) - 1);
        assign timing_o[k*TW +: TW] = st_q.timing[k];
    end

    always_comb begin
        rd_val = '0;
        if (sel.timing) rd_val = DATA_W'(st_q.timing[slot]);
        if (sel.ctrl)   rd_val = DATA_W'(ctrl_w);
        if (sel.base)   rd_val = DATA_W'(st_q.base);
        if (sel.stride) rd_val = DATA_W'(st_q.stride);
        if (sel.mon)    rd_val = DATA_W'({mon_id, {MON_SHIFT{1'b0}}});
        if (sel.div)    rd_val = DATA_W'(st_q.div);
        if (sel.inten)  rd_val = DATA_W'(st_q.inten);
        if (sel.status) rd_val = DATA_W'(status_w);
    end

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        if (bus_wr) begin
            if (sel.timing) st_d.timing[slot] = bus_wdata[TW-1:0] & tmask[slot];
            if (sel.base)   st_d.base   = bus_wdata[BASE_W-1:0] & BASE_KEEP;
            if (sel.stride) st_d.stride = bus_wdata[STRIDE_W-1:0] & STRIDE_KEEP;
            if (sel.div)    st_d.div    = bus_wdata[DIV_W-1:0];
            if (sel.inten)  st_d.inten  = bus_wdata[INTEN_W-1:0];
            st_d.commit = display_on_w &
                          (sel.timing | sel.base | sel.stride | sel.div);
        end
        if (bus_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign fb_base_o    = st_q.base;
    assign row_stride_o = st_q.stride;
    assign clk_div_o    = st_q.div;
    assign display_on_o = display_on_w;
    assign commit_o     = st_q.commit;
endmodule

// File: rtl/vtr_checker.sv
module vtr_checker #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int BASE_W = 22,
    parameter int ST_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              vblank,
    input logic              display_on,
    input logic              irq,
    input logic              commit,
    input logic [ST_W-1:0]   status,
    input logic              inten_irq,
    input logic [BASE_W-1:0] fb_base
);
    // R9: request only when all three conditions held one cycle earlier
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(vblank) && $past(display_on) && $past(inten_irq)));

    // R8: status bits follow the blank level one cycle later
    a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> (status[3:2] == 2'b11));
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !vblank |=> (status[3:2] == 2'b00));

    // R10: reload pulse only after a write made with the display on
    a_r10_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(bus_wr) && $past(display_on)));

    // R7: display state moves only on a control register write
    a_r7_display_source: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(display_on) |-> $past(bus_wr && bus_addr[ADDR_W-1:4] == 5'd18));

    // R6: unmapped reads return zero
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[ADDR_W-1:4] > 5'd26) |=> (bus_rdata == '0));

    // R3: base holds without a write
    a_r3_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(fb_base));
endmodule

bind vtr_regfile vtr_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BASE_W (BASE_W),
    .ST_W   (ST_W)
) u_vtr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .vblank     (vblank),
    .display_on (display_on_o),
    .irq        (irq_o),
    .commit     (commit_o),
    .status     (status_w),
    .inten_irq  (inten_irq_w),
    .fb_base    (fb_base_o)
);

// File: tb/tb_vtr_regfile.sv
`timescale 1ns/1ps
module tb_vtr_regfile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         vblank = 1'b0;
    logic [2:0]   mon_id = 3'd5;
    logic [191:0] timing_o;
    logic [21:0]  fb_base_o;
    logic [14:0]  row_stride_o;
    logic [1:0]   clk_div_o;
    logic         display_on_o, irq_o, commit_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic last_commit;
    logic [31:0] rv;

    always #2 clk = ~clk;

    vtr_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .vblank(vblank), .mon_id(mon_id), .timing_o(timing_o),
        .fb_base_o(fb_base_o), .row_stride_o(row_stride_o),
        .clk_div_o(clk_div_o), .display_on_o(display_on_o),
        .irq_o(irq_o), .commit_o(commit_o)
    );

    typedef struct packed {
        logic [8:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{9'h010, 32'hFFFF_FFFF, 32'h0000_0FFF, 4'd2},  // R2 register 1, 12 bits
        '{9'h080, 32'hFFFF_FFFF, 32'h0000_03FF, 4'd2},  // R2 register 8, 10 bits
        '{9'h0E0, 32'hFFFF_FFFF, 32'h0000_00FF, 4'd2},  // R2 register 14, 8 bits
        '{9'h100, 32'h1234_5678, 32'h0000_0678, 4'd2},  // R2 register 16
        '{9'h130, 32'hFFFF_FFFF, 32'h003F_FFE0, 4'd3},  // R3 base mask
        '{9'h140, 32'hFFFF_FFFF, 32'h0000_7FE0, 4'd3},  // R3 stride mask
        '{9'h170, 32'hFFFF_FFFF, 32'h0000_0003, 4'd4},  // R4 divide
        '{9'h190, 32'hFFFF_FFFF, 32'h0000_000F, 4'd4},  // R4 interrupt enable
        '{9'h110, 32'h0000_0FFF, 32'h0000_0000, 4'd5},  // R5 counter test reads zero
        '{9'h180, 32'h0000_03FF, 32'h0000_0000, 4'd5},  // R5 refresh reads zero
        '{9'h000, 32'h0000_0055, 32'h0000_0000, 4'd5},  // R5 line register reads zero
        '{9'h1E0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd6},  // R6 unmapped
        '{9'h08D, 32'h0000_0001, 32'h0000_0001, 4'd1}   // R1 low offset bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        last_commit = commit_o;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 display", 32'(display_on_o), 32'd0);
        check("R11 irq", 32'(irq_o), 32'd0);
        check("R11 base", 32'(fb_base_o), 32'd0);
        check("R11 rdata", bus_rdata, 32'd0);
        rd(9'h120, rv); check("R11 control", rv, 32'd0);
        rd(9'h010, rv); check("R11 timing", rv, 32'd0);

        // table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].wdata);
            if (i == 0) check("R10 no commit while off", 32'(last_commit), 32'd0);
            rd(VEC[i].addr, rv);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rv, VEC[i].expect_rd);
        end

        // R1 data holds between reads; R2 port view; R6 write had no effect
        @(negedge clk);
        check("R1 rdata hold", bus_rdata, 32'h1);
        check("R2 timing_o slot0", 32'(timing_o[11:0]), 32'hFFF);
        check("R2 timing_o slot7", 32'(timing_o[7*12 +: 12]), 32'h1);
        check("R3 stride port", 32'(row_stride_o), 32'h7FE0);
        check("R4 divide port", 32'(clk_div_o), 32'h3);
        rd(9'h150, rv); check("R5 monitor code", rv, 32'h140);
        wr(9'h160, 32'hFFFF_FFFF);
        rd(9'h160, rv); check("R6 register 22 zero", rv, 32'h0);

        // R9 display off blocks the request
        vblank = 1'b1;
        @(negedge clk);
        check("R9 off blocks irq", 32'(irq_o), 32'd0);
        rd(9'h1A0, rv); check("R8 status set", rv, 32'hC);
        vblank = 1'b0;
        @(negedge clk);

        // R7 strobe sequence to enable
        wr(9'h120, 32'h008);
        wr(9'h120, 32'h000);
        check("R7 two toggles still off", 32'(display_on_o), 32'd0);
        wr(9'h120, 32'h008);
        check("R7 third toggle on", 32'(display_on_o), 32'd1);

        // R10 reload pulse while on
        wr(9'h020, 32'h123);
        check("R10 commit timing", 32'(last_commit), 32'd1);
        @(negedge clk);
        check("R10 single cycle", 32'(commit_o), 32'd0);
        wr(9'h190, 32'hF);
        check("R10 no commit for enable reg", 32'(last_commit), 32'd0);

        // R9 / R8 interrupt with display on
        vblank = 1'b1;
        @(negedge clk);
        check("R9 irq on", 32'(irq_o), 32'd1);
        vblank = 1'b0;
        @(negedge clk);
        check("R9 irq follows low", 32'(irq_o), 32'd0);
        rd(9'h1A0, rv); check("R8 status clear", rv, 32'h0);
        wr(9'h190, 32'h8);
        vblank = 1'b1;
        @(negedge clk);
        check("R9 enable bit2 gates", 32'(irq_o), 32'd0);
        vblank = 1'b0;

        // R7 disable: bit 10 change resets the count
        wr(9'h120, 32'h408);
        wr(9'h120, 32'h400);
        wr(9'h120, 32'h408);
        check("R7 still on after two", 32'(display_on_o), 32'd1);
        wr(9'h120, 32'h400);
        check("R7 off after third", 32'(display_on_o), 32'd0);
        rd(9'h120, rv); check("R4 control readback", rv, 32'h400);
        wr(9'h120, 32'hFFFF_FFFF);
        rd(9'h120, rv); check("R4 control 11 bits", rv, 32'h7FF);
        check("R7 same bit10 no change", 32'(display_on_o), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule